// File: doc/BRIEF.md
# DDR3 Initialization Command Sequencer

This block runs the DDR3 power-up command sequence for a memory controller. A `start` pulse captures the configured CAS latency, CAS write latency and write recovery time. The block then raises a power-up request and waits for the power-up-done status. If that status does not arrive within a programmable number of cycles, the block reports a timeout and returns to idle. If it arrives, the block posts a fixed series of commands, one at a time, through a 32-bit command register. Every command is addressed to both ranks. The series is: deselect, a settling wait, precharge-all, mode-register writes to MR2, MR3, MR1 and MR0, and finally a long ZQ calibration.

The command register works as a valid/ready stream. Bit 31 of `cmd_word` is the start bit and acts as valid. `cmd_ack` is ready. While bit 31 is high, the whole word is held stable; the downstream side may delay `cmd_ack` for any number of cycles (back-pressure). A cycle with both bit 31 and `cmd_ack` high consumes the command, and bit 31 clears on the next edge. `cmd_ack` has no effect while bit 31 is low. The next command is posted no earlier than one cycle after the start bit clears.

The mode-register contents are derived from the captured timing values, using DDR3's bit layouts. `done` pulses once the calibration command has been consumed.

Top module: `ddr3_init_seq`

## Requirements
- R1: Every posted word has bit 31 set, bits 21 and 20 both set (both ranks), the mode-register number in bits [19:17], mode-register data in bits [16:4] and the command code in bits [3:0]. The codes are: deselect 0, precharge-all 1, refresh 2, mode-register set 3, ZQ short 4, ZQ long 5, reset-low 6, mode-register read 8, deep-power-down 9.
- R2: After power-up-done, the words are posted in this order: deselect, precharge-all, MRS to MR2, MRS to MR3, MRS to MR1, MRS to MR0, ZQ long. Commands without a mode register carry zero in bits [19:4].
- R3: While bit 31 is high and `cmd_ack` is low, `cmd_word` holds its value. After a cycle with both high, bit 31 is low on the next cycle. Bit 31 then stays low for at least one cycle before the next command.
- R4: Between the consumption of the deselect and the posting of precharge-all, bit 31 stays low for at least DESEL_WAIT cycles.
- R5: MR0 has bit 8 (DLL reset) set. The write-recovery field in bits [11:9] is computed as follows. A tWR above 8 is first rounded up to even. A value of 8 or less is encoded as tWR−4; a larger value as (tWR/2) mod 8.
- R6: In MR0, bits [6:4] hold (CL−4) mod 8, and bit 2 holds bit 3 of (CL−4). All other MR0 bits are zero.
- R7: MR2 holds (CWL−5) mod 8 in bits [5:3] and zero elsewhere. MR1 equals 0x040 (only bit 6 set). MR3 equals 0.
- R8: While waiting for power-up, `pwr_up_start` is high and no command is posted. If `pwr_up_done` stays low for `tmo_limit` cycles, `timeout_err` rises, `busy` falls and no command is posted. `timeout_err` stays set until the next accepted start.
- R9: `done` is a one-cycle pulse on the cycle after the ZQ-long command is consumed, and `busy` is low at that point.
- R10: `start` is ignored while `busy` is high. Configuration is captured at the accepted start, so later changes to `cfg_*` do not alter the words of a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (accepted only while idle) |
| cfg_cl | input | 5 | CAS latency in clocks |
| cfg_cwl | input | 5 | CAS write latency in clocks |
| cfg_twr | input | 5 | Write recovery time in clocks |
| tmo_limit | input | 16 | Cycles allowed for power-up-done |
| pwr_up_start | output | 1 | Power-up request, high while waiting |
| pwr_up_done | input | 1 | Power-up completion status |
| cmd_word | output | 32 | Command register; bit 31 is the start bit (valid) |
| cmd_ack | input | 1 | Downstream consumed the command (ready) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Power-up timeout flag |

## Verification
The hardest case to reach from the ports combines a second `start` pulse and a change of every configuration input in the middle of a sequence, while the command register is stalled by a late acknowledge. The bench reaches it by holding `cmd_ack` back for several cycles on each word. While a word is stalled, it changes the configuration inputs and pulses `start` again. It then checks that every remaining word still carries the values captured at the first start. The timeout path is reached by keeping the modelled power-up status low past the limit. The deselect settling gap is measured by counting the cycles in which the start bit is low before precharge-all appears.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;
  localparam int WORD_W  = 32;
  localparam int GO_BIT  = 31;
  localparam int RK1_BIT = 21;
  localparam int RK0_BIT = 20;
  localparam int MRN_LSB = 17;
  localparam int MRN_W   = 3;
  localparam int MRD_LSB = 4;
  localparam int MRD_W   = 13;
  localparam int CODE_W  = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQS   = 4'd4,
    OP_ZQL   = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8,
    OP_DPDE  = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_POST, ST_WAIT, ST_GAP
  } seq_state_e;

  // Builds the command body (bits 30:0); the start bit is added by the poster.
  function automatic logic [WORD_W-2:0] pack_body(op_e op, logic [MRN_W-1:0] mrn,
                                                  logic [MRD_W-1:0] data);
    logic [WORD_W-2:0] b;
    b = '0;
    b[RK1_BIT] = 1'b1;
    b[RK0_BIT] = 1'b1;
    b[MRN_LSB +: MRN_W] = mrn;
    b[MRD_LSB +: MRD_W] = data;
    b[CODE_W-1:0] = op;
    return b;
  endfunction
endpackage

// File: rtl/ddr3i_mr_encoder.sv
module ddr3i_mr_encoder
  import ddr3i_pkg::*;
#(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cl,
  input  logic [CFG_W-1:0] cwl,
  input  logic [CFG_W-1:0] twr,
  output logic [MRD_W-1:0] mr0,
  output logic [MRD_W-1:0] mr1,
  output logic [MRD_W-1:0] mr2,
  output logic [MRD_W-1:0] mr3
);
  localparam logic [CFG_W-1:0] ONE   = CFG_W'(1);
  localparam logic [CFG_W-1:0] FOUR  = CFG_W'(4);
  localparam logic [CFG_W-1:0] FIVE  = CFG_W'(5);
  localparam logic [CFG_W-1:0] EIGHT = CFG_W'(8);

  logic [CFG_W-1:0] cl_q, cwl_q, twr_q;
  logic [CFG_W-1:0] twr_even;
  logic [2:0]       wr_fld;
  logic [3:0]       cl_m4;
  logic [2:0]       cwl_m5;

  // Configuration is frozen at the accepted start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q  <= '0;
      cwl_q <= '0;
      twr_q <= '0;
    end else if (load) begin
      cl_q  <= cl;
      cwl_q <= cwl;
      twr_q <= twr;
    end
  end

  always_comb begin
    // Write recovery above 8 only has even encodings: round up.
    twr_even = (twr_q > EIGHT) ? ((twr_q + ONE) & ~ONE) : twr_q;
    wr_fld   = (twr_even <= EIGHT) ? 3'(twr_even - FOUR) : 3'(twr_even >> 1);
    cl_m4    = 4'(cl_q - FOUR);
    cwl_m5   = 3'(cwl_q - FIVE);

    mr0      = '0;
    mr0[11:9] = wr_fld;
    mr0[8]    = 1'b1;
    mr0[6:4]  = cl_m4[2:0];
    mr0[2]    = cl_m4[3];

    mr1      = '0;
    mr1[6]   = 1'b1;

    mr2      = '0;
    mr2[5:3] = cwl_m5;

    mr3      = '0;
  end
endmodule

// File: rtl/ddr3i_cmd_poster.sv
module ddr3i_cmd_poster
  import ddr3i_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [WORD_W-2:0] body,
  input  logic              ack,
  output logic [WORD_W-1:0] word,
  output logic              consumed
);
  logic [WORD_W-1:0] word_q;

  assign consumed = ack & word_q[GO_BIT];
  assign word     = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (post) begin
      word_q <= {1'b1, body};
    end else if (consumed) begin
      word_q[GO_BIT] <= 1'b0;   // self-clearing start bit
    end
  end
endmodule

// File: rtl/ddr3i_seq_ctrl.sv
module ddr3i_seq_ctrl
  import ddr3i_pkg::*;
#(
  parameter int TMO_W      = 16,
  parameter int DESEL_WAIT = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              pwr_up_done,
  input  logic [MRD_W-1:0]  mr0,
  input  logic [MRD_W-1:0]  mr1,
  input  logic [MRD_W-1:0]  mr2,
  input  logic [MRD_W-1:0]  mr3,
  input  logic              consumed,
  output logic              load_cfg,
  output logic              post,
  output logic [WORD_W-2:0] post_body,
  output logic              pwr_up_start,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  localparam int          GAP_W = $clog2(DESEL_WAIT + 1);
  localparam logic [2:0]  LAST  = 3'd6;

  seq_state_e        state;
  logic [2:0]        step;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic              tmo_hit;

  assign load_cfg     = start && (state == ST_IDLE);
  assign post         = (state == ST_POST);
  assign pwr_up_start = (state == ST_PWR);
  assign busy         = (state != ST_IDLE);
  assign tmo_hit      = ({1'b0, tmo_cnt} + 1'b1) >= {1'b0, tmo_limit};

  always_comb begin
    case (step)
      3'd0:    post_body = pack_body(OP_DESEL, 3'd0, '0);
      3'd1:    post_body = pack_body(OP_PREA,  3'd0, '0);
      3'd2:    post_body = pack_body(OP_MRS,   3'd2, mr2);
      3'd3:    post_body = pack_body(OP_MRS,   3'd3, mr3);
      3'd4:    post_body = pack_body(OP_MRS,   3'd1, mr1);
      3'd5:    post_body = pack_body(OP_MRS,   3'd0, mr0);
      default: post_body = pack_body(OP_ZQL,   3'd0, '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step        <= '0;
      tmo_cnt     <= '0;
      gap_cnt     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state       <= ST_PWR;
          tmo_cnt     <= '0;
          timeout_err <= 1'b0;
        end
        ST_PWR: begin
          if (pwr_up_done) begin
            step  <= '0;
            state <= ST_POST;
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        ST_POST: state <= ST_WAIT;
        ST_WAIT: if (consumed) begin
          if (step == LAST) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (step == 3'd0) begin
            gap_cnt <= '0;
            state   <= ST_GAP;
          end else begin
            step  <= step + 1'b1;
            state <= ST_POST;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(DESEL_WAIT - 1)) begin
            step  <= 3'd1;
            state <= ST_POST;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3i_pkg::*;
#(
  parameter int CFG_W      = 5,
  parameter int TMO_W      = 16,
  parameter int DESEL_WAIT = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CFG_W-1:0]  cfg_cl,
  input  logic [CFG_W-1:0]  cfg_cwl,
  input  logic [CFG_W-1:0]  cfg_twr,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              pwr_up_start,
  input  logic              pwr_up_done,
  output logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_ack,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  logic              load_cfg, post, consumed;
  logic [WORD_W-2:0] body;
  logic [MRD_W-1:0]  mr0, mr1, mr2, mr3;

  ddr3i_mr_encoder #(.CFG_W(CFG_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .load(load_cfg),
    .cl(cfg_cl), .cwl(cfg_cwl), .twr(cfg_twr),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3)
  );

  ddr3i_seq_ctrl #(.TMO_W(TMO_W), .DESEL_WAIT(DESEL_WAIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
    .pwr_up_done(pwr_up_done), .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
    .consumed(consumed), .load_cfg(load_cfg), .post(post), .post_body(body),
    .pwr_up_start(pwr_up_start), .busy(busy), .done(done),
    .timeout_err(timeout_err)
  );

  ddr3i_cmd_poster u_post (
    .clk(clk), .rst_n(rst_n), .post(post), .body(body), .ack(cmd_ack),
    .word(cmd_word), .consumed(consumed)
  );
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cmd_word,
  input logic        cmd_ack,
  input logic        pwr_up_start,
  input logic        busy,
  input logic        done,
  input logic        timeout_err
);
  a_r1_both_ranks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_word[31] |-> (cmd_word[21:20] == 2'b11));

  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[31] && !cmd_ack) |=> $stable(cmd_word));

  a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[31] && cmd_ack) |=> !cmd_word[31]);

  a_r8_no_cmd_in_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up_start |-> !cmd_word[31]);

  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !cmd_word[31]);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind ddr3_init_seq ddr3_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_ack(cmd_ack),
  .pwr_up_start(pwr_up_start), .busy(busy), .done(done),
  .timeout_err(timeout_err)
);

// File: tb/tb_ddr3_init_seq.sv
module tb_ddr3_init_seq;
  localparam int DESEL_WAIT = 125;

  typedef struct { logic [31:0] w; string tag; } exp_t;

  logic        clk = 0, rst_n = 0, start = 0, pwr_up_done, cmd_ack = 0;
  logic [4:0]  cfg_cl = 6, cfg_cwl = 5, cfg_twr = 6;
  logic [15:0] tmo_limit = 16'd40;
  logic        pwr_up_start, busy, done, timeout_err;
  logic [31:0] cmd_word;

  int checks = 0, fails = 0;
  int ack_delay = 0;
  int pwr_lat = 5;
  bit pwr_en = 1;
  int pwr_cnt = 0;
  exp_t exp_q[$];

  ddr3_init_seq #(.DESEL_WAIT(DESEL_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
    .cfg_twr(cfg_twr), .tmo_limit(tmo_limit), .pwr_up_start(pwr_up_start),
    .pwr_up_done(pwr_up_done), .cmd_word(cmd_word), .cmd_ack(cmd_ack),
    .busy(busy), .done(done), .timeout_err(timeout_err)
  );

  always #4 clk = ~clk;

  // Power-up responder model.
  always @(posedge clk) pwr_cnt <= pwr_up_start ? pwr_cnt + 1 : 0;
  assign pwr_up_done = pwr_en && pwr_up_start && (pwr_cnt >= pwr_lat);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int code, int mrn, int data);
    return 32'h8030_0000 | (32'(mrn) << 17) | (32'(data) << 4) | 32'(code);
  endfunction

  function automatic int enc_mr0(int cl, int twr);
    int t = twr, wr, c = cl - 4;
    if (t > 8) t = t + (t % 2);
    wr = (t <= 8) ? (t - 4) : ((t / 2) % 8);
    return (wr << 9) | (1 << 8) | ((c % 8) << 4) | (((c / 8) % 2) << 2);
  endfunction

  task automatic push(logic [31:0] w, string tag);
    exp_t e;
    e.w = w; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: pushes the expected words, starts, waits for done.
  task automatic run_seq(int cl, int cwl, int twr, int dly, bit disturb);
    bit seen = 0;
    ack_delay = dly;
    cfg_cl = 5'(cl); cfg_cwl = 5'(cwl); cfg_twr = 5'(twr);
    push(mk(0, 0, 0), "R2 deselect");
    push(mk(1, 0, 0), "R2 precharge");
    push(mk(3, 2, ((cwl - 5) % 8) << 3), "R7 MR2");
    push(mk(3, 3, 0), "R7 MR3");
    push(mk(3, 1, 'h40), "R7 MR1");
    push(mk(3, 0, enc_mr0(cl, twr)), "R5 R6 MR0");
    push(mk(5, 0, 0), "R2 zqcl");
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(pwr_up_start && !cmd_word[31], "R8 powerup wait", {31'b0, pwr_up_start}, 32'd1);
    if (disturb) begin
      repeat (pwr_lat + 4) @(negedge clk);
      // R10: new config and a second start mid-sequence must be ignored
      cfg_cl = 5'd13; cfg_cwl = 5'd12; cfg_twr = 5'd5;
      start = 1; @(negedge clk); start = 0;
    end
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen && !busy, "R9 done pulse", {31'b0, seen}, 32'd1);
    @(negedge clk);
    check(!done, "R9 done one cycle", {31'b0, done}, 32'd0);
    check(exp_q.size() == 0, "R2 all words issued", exp_q.size(), 0);
  endtask

  // Monitor: pops expected words and acknowledges with a delay.
  initial begin
    int lowcnt = 0;
    logic [3:0] prev = 4'hf;
    logic [31:0] w;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_word[31]) begin
        w = cmd_word;
        if (w[3:0] == 4'd1 && prev == 4'd0)
          check(lowcnt >= DESEL_WAIT, "R4 deselect gap", lowcnt, DESEL_WAIT);
        else if (prev != 4'hf)
          check(lowcnt >= 1, "R3 gap between commands", lowcnt, 1);
        check(w[21:20] == 2'b11, "R1 both ranks", w, w | 32'h0030_0000);
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected command", w, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(w == e.w, e.tag, w, e.w);
        end
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          check(cmd_word == w, "R3 hold while stalled", cmd_word, w);
        end
        cmd_ack = 1;
        @(negedge clk);
        cmd_ack = 0;
        check(!cmd_word[31], "R3 start bit cleared", cmd_word, w & 32'h7fff_ffff);
        lowcnt = 1;
        prev = w[3:0];
      end else begin
        lowcnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !timeout_err && !cmd_word[31] && !pwr_up_start,
          "R9 reset state", {busy, done, timeout_err, cmd_word[31], pwr_up_start}, 0);
    run_seq(6, 5, 6, 0, 0);      // low latencies, immediate ack
    run_seq(11, 8, 12, 3, 0);    // CL 11, tWR 12
    run_seq(12, 10, 9, 1, 0);    // CL bit 3 path, tWR 9 rounds to 10
    run_seq(7, 6, 16, 2, 1);     // tWR 16 wraps to 0, disturbance
    run_seq(5, 7, 15, 0, 0);     // tWR 15 rounds to 16
    // R8: power-up never completes
    pwr_en = 0; tmo_limit = 16'd20;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    check(timeout_err && !busy, "R8 timeout flag", {30'b0, timeout_err, busy}, 32'd2);
    check(exp_q.size() == 0 && !cmd_word[31], "R8 no command after timeout", cmd_word, 0);
    // R8: late but in-limit completion clears the flag and runs normally
    pwr_en = 1; pwr_lat = 15;
    run_seq(8, 6, 8, 1, 0);
    check(!timeout_err, "R8 flag cleared by new start", {31'b0, timeout_err}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule